// File: doc/BRIEF.md
# Translation Walk Request Scheduler

This block sits between a processor's address-translation misses and a single page-table walk engine. Requests carry a virtual address, an access type (read or write) and a requester tag. They are held in arrival order in a circular queue, and the block hands them to the engine one at a time over a start/done handshake. It returns one completion per request, carrying the tag, a fault flag and the physical address. When the engine is idle and the queue is empty, a new request is launched straight away. Otherwise it waits its turn.

The requester can withdraw a request at any time by raising the cancel bit of the queue slot that the request occupies. The k-th request accepted since reset occupies slot k mod DEPTH.

A pending head entry that is cancelled is dropped before the next launch, and a fault completion is returned for it. Each scheduling pass drops at most SQUASH_MAX such entries. A walk that is cancelled while the engine is working on it is answered at once with a fault. That walk's slot stays occupied until the engine reports done, which means its memory traffic has drained. The engine's result for that walk is then discarded.

The control is a five-state machine:

| State | Role |
|---|---|
| IDLE | Queue empty, nothing running. |
| WALK | The head entry is with the engine. |
| DRAIN | A cancelled walk is waiting for the engine to finish. |
| SETTLE | One dead cycle after a walk ends. |
| PURGE | The cancel pass over the head, followed by the launch. |

The transitions are:

| From | Condition | To |
|---|---|---|
| IDLE | A request is accepted | WALK, with a start pulse |
| WALK | Done arrives and entries remain | SETTLE |
| WALK | Done arrives and the queue is empty | IDLE |
| WALK | The head is cancelled and done is absent | DRAIN |
| DRAIN | Done arrives and entries remain | SETTLE |
| DRAIN | Done arrives and the queue is empty | IDLE |
| SETTLE | Always | PURGE |
| PURGE | The head is cancelled and the limit is not reached | PURGE, dropping the head |
| PURGE | Otherwise, with a head present | WALK, with a start pulse |
| PURGE | The queue is empty | IDLE, or WALK with a start pulse if a request arrives in that cycle |

Top module: `xlat_walk_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, the queue is empty: `req_ready_o` is 1, and `walk_start_o` and `cpl_valid_o` are 0.
- R2: A request accepted while the block is idle with an empty queue makes `walk_start_o` pulse for one cycle in the cycle after the accepting edge. In that cycle `walk_vaddr_o` and `walk_write_o` carry the request's fields.
- R3: Walks are started one at a time, in the order requests were accepted. No start pulse occurs while a walk is outstanding.
- R4: A `walk_done_i` sampled at a clock edge for a live walk pops that entry. In the next cycle `cpl_valid_o` is 1, with that entry's tag, `walk_fault_i` as the fault flag and `walk_paddr_i` as the address. If entries remain, the next start pulse comes no sooner than the cycle after the second edge following the done edge (one settle cycle).
- R5: During the cancel pass, a head entry whose slot's cancel bit is 1 is removed, one entry per cycle. Each removal produces a completion in the next cycle with fault 1 and address 0.
- R6: A pass removes at most SQUASH_MAX cancelled entries. The head that remains after that is started even if its cancel bit is still 1.
- R7: If the active walk's cancel bit is 1 at an edge where `walk_done_i` is 0, a fault completion (fault 1, address 0) is issued in the next cycle. The later done for that walk produces no completion, and the slot is held until that done.
- R8: `req_ready_o` is 0 exactly when DEPTH entries are held, counting the one being walked. A request is accepted at an edge only when both `req_valid_i` and `req_ready_o` are 1.
- R9: The k-th accepted request uses slot k mod DEPTH. A cancel bit on a slot that holds no entry has no effect on any completion or start.
- R10: When `walk_done_i` and the active walk's cancel bit are both 1 at the same edge, the done takes priority and the normal completion with the engine's result is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | A translation request is offered |
| req_ready_o | output | 1 | The queue has room for a request |
| req_vaddr_i | input | VA_W | Virtual address of the request |
| req_write_i | input | 1 | 1 for a write access, 0 for a read |
| req_tag_i | input | TAG_W | Requester tag, returned with the completion |
| cancel_i | input | DEPTH | Per-slot cancel status; bit s applies to the entry in slot s |
| walk_start_o | output | 1 | One-cycle pulse that launches a walk |
| walk_vaddr_o | output | VA_W | Virtual address of the head entry |
| walk_write_o | output | 1 | Access type of the head entry |
| walk_done_i | input | 1 | The engine has finished the walk and has nothing in flight |
| walk_fault_i | input | 1 | The finished walk faulted |
| walk_paddr_i | input | PA_W | Physical address result of the finished walk |
| cpl_valid_o | output | 1 | A completion is presented this cycle |
| cpl_tag_o | output | TAG_W | Tag of the completed request |
| cpl_fault_o | output | 1 | The completion is a fault |
| cpl_paddr_o | output | PA_W | Translated address; 0 for a cancelled entry |

## Verification
Every result of this block appears exactly one cycle after the edge that decides it:
- An idle launch shows one cycle after the accepting edge.
- A completion shows one cycle after the done edge, the squash edge or the purge edge.
- After a done with entries left, the next launch comes only after a settle cycle and a purge decision.

The reference model advances at each rising edge, using the same input values the design samples there. The bench compares the ready, start, head fields and completion outputs at the following falling edge. This keeps every check at the cycle where the change is due. Directed scenarios place the engine's done in a known cycle so that the same-edge cancel case, the purge limit and the drain of a cancelled walk are each exercised.

// File: rtl/xws_pkg.sv
package xws_pkg;

    // Control states of the walk scheduler
    typedef enum logic [2:0] {
        ST_IDLE,    // queue empty, engine idle
        ST_WALK,    // head entry is being walked
        ST_DRAIN,   // head entry cancelled, waiting for engine to drain
        ST_SETTLE,  // dead cycle after a walk ends
        ST_PURGE    // cancel pass over the head, then launch
    } walk_state_e;

endpackage

// File: rtl/xws_queue.sv
module xws_queue #(
    parameter int DEPTH = 8,
    parameter int VA_W  = 39,
    parameter int TAG_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_i,
    input  logic [VA_W-1:0]          va_i,
    input  logic                     wr_i,
    input  logic [TAG_W-1:0]         tag_i,
    input  logic                     pop_i,
    output logic [VA_W-1:0]          head_va_o,
    output logic                     head_wr_o,
    output logic [TAG_W-1:0]         head_tag_o,
    output logic [$clog2(DEPTH)-1:0] head_slot_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic                     full_o
);

    localparam int SLOT_W = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH+1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DEPTH-1);

    logic [VA_W-1:0]  va_mem  [DEPTH];
    logic             wr_mem  [DEPTH];
    logic [TAG_W-1:0] tag_mem [DEPTH];

    logic [SLOT_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  count_q;

    // entry storage, written at the tail slot
    always_ff @(posedge clk) begin
        if (push_i) begin
            va_mem[wr_ptr_q]  <= va_i;
            wr_mem[wr_ptr_q]  <= wr_i;
            tag_mem[wr_ptr_q] <= tag_i;
        end
    end

    // circular pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_i)
                wr_ptr_q <= (wr_ptr_q == LAST_SLOT) ? '0 : wr_ptr_q + 1'b1;
            if (pop_i)
                rd_ptr_q <= (rd_ptr_q == LAST_SLOT) ? '0 : rd_ptr_q + 1'b1;
            unique case ({push_i, pop_i})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign head_va_o   = va_mem[rd_ptr_q];
    assign head_wr_o   = wr_mem[rd_ptr_q];
    assign head_tag_o  = tag_mem[rd_ptr_q];
    assign head_slot_o = rd_ptr_q;
    assign count_o     = count_q;
    assign full_o      = (count_q == CNT_W'(DEPTH));

    // R8
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    // R8
    push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (count_q != CNT_W'(DEPTH)));

    // R3
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (count_q != '0));

endmodule

// File: rtl/xws_ctrl.sv
module xws_ctrl
    import xws_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int PA_W       = 56,
    parameter int SQUASH_MAX = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       accept_i,
    input  logic [$clog2(DEPTH+1)-1:0] count_i,
    input  logic                       head_cancel_i,
    input  logic                       walk_done_i,
    input  logic                       walk_fault_i,
    input  logic [PA_W-1:0]            walk_paddr_i,
    output logic                       pop_o,
    output logic                       walk_start_o,
    output logic                       cpl_load_o,
    output logic                       cpl_fault_o,
    output logic [PA_W-1:0]            cpl_paddr_o
);

    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int PC_W  = $clog2(SQUASH_MAX+1);

    walk_state_e state_q, state_d;
    logic            start_d, start_q;
    logic            purge_inc, purge_clr;
    logic [PC_W-1:0] purged_q;
    logic            remain_after_pop;

    // entries left once the head is popped, counting an arrival this cycle
    assign remain_after_pop = (count_i > CNT_W'(1)) || accept_i;

    // next-state and decision logic
    always_comb begin
        state_d     = state_q;
        start_d     = 1'b0;
        pop_o       = 1'b0;
        cpl_load_o  = 1'b0;
        cpl_fault_o = 1'b0;
        cpl_paddr_o = '0;
        purge_inc   = 1'b0;
        purge_clr   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_i) begin
                    state_d = ST_WALK;
                    start_d = 1'b1;
                end
            end
            ST_WALK: begin
                if (walk_done_i) begin
                    pop_o       = 1'b1;
                    cpl_load_o  = 1'b1;
                    cpl_fault_o = walk_fault_i;
                    cpl_paddr_o = walk_paddr_i;
                    state_d     = remain_after_pop ? ST_SETTLE : ST_IDLE;
                end else if (head_cancel_i) begin
                    cpl_load_o  = 1'b1;
                    cpl_fault_o = 1'b1;
                    state_d     = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (walk_done_i) begin
                    pop_o   = 1'b1;
                    state_d = remain_after_pop ? ST_SETTLE : ST_IDLE;
                end
            end
            ST_SETTLE: begin
                purge_clr = 1'b1;
                state_d   = ST_PURGE;
            end
            ST_PURGE: begin
                if (count_i == '0) begin
                    if (accept_i) begin
                        state_d = ST_WALK;
                        start_d = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else if (head_cancel_i && (purged_q < PC_W'(SQUASH_MAX))) begin
                    pop_o       = 1'b1;
                    cpl_load_o  = 1'b1;
                    cpl_fault_o = 1'b1;
                    purge_inc   = 1'b1;
                end else begin
                    state_d = ST_WALK;
                    start_d = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and pass counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= 1'b0;
            purged_q <= '0;
        end else begin
            start_q <= start_d;
            if (purge_clr)      purged_q <= '0;
            else if (purge_inc) purged_q <= purged_q + 1'b1;
        end
    end

    assign walk_start_o = start_q;

    // R4
    settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WALK || state_q == ST_DRAIN) && walk_done_i) |=> !start_q);

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);

    // R6
    purge_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        purged_q <= PC_W'(SQUASH_MAX));

    // R3
    start_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> (state_q == ST_WALK));

    // R7
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && !walk_done_i) |=> (state_q == ST_DRAIN));

endmodule

// File: rtl/xws_cpl_reg.sv
module xws_cpl_reg #(
    parameter int TAG_W = 4,
    parameter int PA_W  = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             fault_i,
    input  logic [PA_W-1:0]  paddr_i,
    output logic             valid_o,
    output logic [TAG_W-1:0] tag_o,
    output logic             fault_o,
    output logic [PA_W-1:0]  paddr_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            tag_o   <= '0;
            fault_o <= 1'b0;
            paddr_o <= '0;
        end else begin
            valid_o <= load_i;
            if (load_i) begin
                tag_o   <= tag_i;
                fault_o <= fault_i;
                paddr_o <= paddr_i;
            end
        end
    end

endmodule

// File: rtl/xlat_walk_sched.sv
module xlat_walk_sched #(
    parameter int DEPTH      = 8,
    parameter int VA_W       = 39,
    parameter int PA_W       = 56,
    parameter int TAG_W      = 4,
    parameter int SQUASH_MAX = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic [VA_W-1:0]  req_vaddr_i,
    input  logic             req_write_i,
    input  logic [TAG_W-1:0] req_tag_i,
    input  logic [DEPTH-1:0] cancel_i,
    output logic             walk_start_o,
    output logic [VA_W-1:0]  walk_vaddr_o,
    output logic             walk_write_o,
    input  logic             walk_done_i,
    input  logic             walk_fault_i,
    input  logic [PA_W-1:0]  walk_paddr_i,
    output logic             cpl_valid_o,
    output logic [TAG_W-1:0] cpl_tag_o,
    output logic             cpl_fault_o,
    output logic [PA_W-1:0]  cpl_paddr_o
);

    localparam int SLOT_W = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH+1);

    logic              accept, pop, full;
    logic [SLOT_W-1:0] head_slot;
    logic [CNT_W-1:0]  count;
    logic [TAG_W-1:0]  head_tag;
    logic              head_cancel;
    logic              cpl_load, cpl_fault_d;
    logic [PA_W-1:0]   cpl_paddr_d;

    assign req_ready_o = !full;
    assign accept      = req_valid_i && !full;
    assign head_cancel = cancel_i[head_slot];

    xws_queue #(
        .DEPTH (DEPTH),
        .VA_W  (VA_W),
        .TAG_W (TAG_W)
    ) queue_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (accept),
        .va_i        (req_vaddr_i),
        .wr_i        (req_write_i),
        .tag_i       (req_tag_i),
        .pop_i       (pop),
        .head_va_o   (walk_vaddr_o),
        .head_wr_o   (walk_write_o),
        .head_tag_o  (head_tag),
        .head_slot_o (head_slot),
        .count_o     (count),
        .full_o      (full)
    );

    xws_ctrl #(
        .DEPTH      (DEPTH),
        .PA_W       (PA_W),
        .SQUASH_MAX (SQUASH_MAX)
    ) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .accept_i      (accept),
        .count_i       (count),
        .head_cancel_i (head_cancel),
        .walk_done_i   (walk_done_i),
        .walk_fault_i  (walk_fault_i),
        .walk_paddr_i  (walk_paddr_i),
        .pop_o         (pop),
        .walk_start_o  (walk_start_o),
        .cpl_load_o    (cpl_load),
        .cpl_fault_o   (cpl_fault_d),
        .cpl_paddr_o   (cpl_paddr_d)
    );

    xws_cpl_reg #(
        .TAG_W (TAG_W),
        .PA_W  (PA_W)
    ) cpl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (cpl_load),
        .tag_i   (head_tag),
        .fault_i (cpl_fault_d),
        .paddr_i (cpl_paddr_d),
        .valid_o (cpl_valid_o),
        .tag_o   (cpl_tag_o),
        .fault_o (cpl_fault_o),
        .paddr_o (cpl_paddr_o)
    );

    // R4
    good_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid_o && !cpl_fault_o) |-> $past(walk_done_i));

    // R5
    cancel_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid_o && !$past(walk_done_i)) |-> (cpl_fault_o && cpl_paddr_o == '0));

endmodule

// File: tb/xlat_walk_sched_tb_top.sv
module xlat_walk_sched_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int VA_W  = 32;
    localparam int PA_W  = 40;
    localparam int TAG_W = 6;
    localparam int SQM   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic req_write = 1'b0;
    logic [TAG_W-1:0] req_tag = '0;
    logic [DEPTH-1:0] cancel_r = '0;
    logic walk_done = 1'b0;
    logic walk_fault = 1'b0;
    logic [PA_W-1:0] walk_paddr = '0;

    logic req_ready_o, walk_start_o, walk_write_o;
    logic [VA_W-1:0] walk_vaddr_o;
    logic cpl_valid_o, cpl_fault_o;
    logic [TAG_W-1:0] cpl_tag_o;
    logic [PA_W-1:0] cpl_paddr_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_walk_sched #(
        .DEPTH(DEPTH), .VA_W(VA_W), .PA_W(PA_W), .TAG_W(TAG_W), .SQUASH_MAX(SQM)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready_o),
        .req_vaddr_i(req_vaddr), .req_write_i(req_write), .req_tag_i(req_tag),
        .cancel_i(cancel_r),
        .walk_start_o(walk_start_o), .walk_vaddr_o(walk_vaddr_o), .walk_write_o(walk_write_o),
        .walk_done_i(walk_done), .walk_fault_i(walk_fault), .walk_paddr_i(walk_paddr),
        .cpl_valid_o(cpl_valid_o), .cpl_tag_o(cpl_tag_o),
        .cpl_fault_o(cpl_fault_o), .cpl_paddr_o(cpl_paddr_o)
    );

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    // ---------------- behavioural reference model ----------------
    typedef struct {
        logic [VA_W-1:0]  va;
        logic             wr;
        logic [TAG_W-1:0] tag;
        int               slot;
    } ent_t;

    ent_t mq[$];
    ent_t m_e;
    int   mstate = 0;   // 0 idle, 1 walk, 2 drain, 3 settle, 4 purge
    int   mpurged = 0;
    int   mslot = 0;
    bit   m_acc, m_hc;
    bit   exp_ready = 1'b1, exp_start = 1'b0, exp_cv = 1'b0, exp_wr = 1'b0, exp_fault = 1'b0;
    logic [VA_W-1:0]  exp_va = '0;
    logic [TAG_W-1:0] exp_tag = '0;
    logic [PA_W-1:0]  exp_pa = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            mstate = 0; mpurged = 0; mslot = 0;
            exp_ready = 1'b1; exp_start = 1'b0; exp_cv = 1'b0;
        end else begin
            m_acc = req_valid && (mq.size() < DEPTH);
            m_hc  = (mq.size() > 0) ? cancel_r[mq[0].slot] : 1'b0;
            exp_start = 1'b0;
            exp_cv = 1'b0;
            case (mstate)
                0: if (m_acc) begin mstate = 1; exp_start = 1'b1; end
                1: begin
                    if (walk_done) begin
                        exp_cv = 1'b1; exp_tag = mq[0].tag;
                        exp_fault = walk_fault; exp_pa = walk_paddr;
                        void'(mq.pop_front());
                        mstate = ((mq.size() > 0) || m_acc) ? 3 : 0;
                    end else if (m_hc) begin
                        exp_cv = 1'b1; exp_tag = mq[0].tag; exp_fault = 1'b1; exp_pa = '0;
                        mstate = 2;
                    end
                end
                2: if (walk_done) begin
                    void'(mq.pop_front());
                    mstate = ((mq.size() > 0) || m_acc) ? 3 : 0;
                end
                3: begin mstate = 4; mpurged = 0; end
                default: begin
                    if (mq.size() == 0) begin
                        if (m_acc) begin mstate = 1; exp_start = 1'b1; end
                        else mstate = 0;
                    end else if (m_hc && mpurged < SQM) begin
                        exp_cv = 1'b1; exp_tag = mq[0].tag; exp_fault = 1'b1; exp_pa = '0;
                        void'(mq.pop_front());
                        mpurged++;
                    end else begin
                        exp_start = 1'b1; mstate = 1;
                    end
                end
            endcase
            if (m_acc) begin
                m_e.va = req_vaddr; m_e.wr = req_write; m_e.tag = req_tag; m_e.slot = mslot;
                mslot = (mslot + 1) % DEPTH;
                mq.push_back(m_e);
            end
            if (exp_start) begin exp_va = mq[0].va; exp_wr = mq[0].wr; end
            exp_ready = (mq.size() < DEPTH);
        end
    end

    // ---------------- comparison and walk engine ----------------
    int eng_cnt = 0;
    int eng_lat = 3;
    logic [VA_W-1:0] eng_va = '0;
    bit mism;

    always @(negedge clk) begin
        if (rst_n) begin
            mism = (req_ready_o !== exp_ready) || (walk_start_o !== exp_start) ||
                   (exp_start && ((walk_vaddr_o !== exp_va) || (walk_write_o !== exp_wr))) ||
                   (cpl_valid_o !== exp_cv) ||
                   (exp_cv && ((cpl_tag_o !== exp_tag) || (cpl_fault_o !== exp_fault) ||
                               (cpl_paddr_o !== exp_pa)));
            checks++;
            if (mism) begin
                fails++;
                $display("FAIL %s t=%0t actual rdy=%b st=%b va=%h wr=%b cv=%b tag=%h f=%b pa=%h expected rdy=%b st=%b va=%h wr=%b cv=%b tag=%h f=%b pa=%h",
                    cur_req, $time, req_ready_o, walk_start_o, walk_vaddr_o, walk_write_o,
                    cpl_valid_o, cpl_tag_o, cpl_fault_o, cpl_paddr_o,
                    exp_ready, exp_start, exp_va, exp_wr, exp_cv, exp_tag, exp_fault, exp_pa);
            end
        end
        walk_done = 1'b0;
        if (eng_cnt > 0) begin
            eng_cnt--;
            if (eng_cnt == 0) begin
                walk_done  = 1'b1;
                walk_fault = (eng_va[3:0] == 4'hF);
                walk_paddr = {8'h3C, eng_va};
            end
        end
        if (walk_start_o === 1'b1) begin
            eng_cnt = eng_lat;
            eng_va  = walk_vaddr_o;
        end
    end

    // ---------------- stimulus ----------------
    int nslot = 0;

    task automatic send(input logic [VA_W-1:0] va, input logic wr,
                        input logic [TAG_W-1:0] tg, output int slot);
        req_vaddr = va; req_write = wr; req_tag = tg; req_valid = 1'b1;
        while (req_ready_o !== 1'b1) @(negedge clk);
        slot = nslot;
        nslot = (nslot + 1) % DEPTH;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_quiet();
        while (!(mq.size() == 0 && mstate == 0 && eng_cnt == 0)) @(negedge clk);
        repeat (4) @(negedge clk);
        cancel_r = '0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog %s: run did not end, actual hung expected finished", cur_req);
        finish_run();
    end

    initial begin : stim
        int sa, sb, sc, sd;
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        checks++;
        if (req_ready_o !== 1'b1 || walk_start_o !== 1'b0 || cpl_valid_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset state actual rdy=%b st=%b cv=%b expected 1 0 0",
                     req_ready_o, walk_start_o, cpl_valid_o);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        cur_req = "R2"; eng_lat = 3;
        send(32'h0000_1000, 1'b0, 6'd1, sa);
        wait_quiet();

        cur_req = "R3";
        send(32'h0000_2000, 1'b1, 6'd2, sa);
        send(32'h0000_3000, 1'b0, 6'd3, sb);
        send(32'h0000_400F, 1'b0, 6'd4, sc);
        wait_quiet();

        cur_req = "R4"; eng_lat = 1;
        send(32'h0000_600F, 1'b0, 6'd6, sa);
        send(32'h0000_7000, 1'b1, 6'd7, sb);
        wait_quiet();

        cur_req = "R8"; eng_lat = 12;
        for (int i = 0; i < 6; i++)
            send(32'h0001_0000 + 32'(i * 16), i[0], 6'(10 + i), sa);
        wait_quiet();

        cur_req = "R5"; eng_lat = 6;
        send(32'h0002_0000, 1'b0, 6'd20, sa);
        send(32'h0002_1000, 1'b1, 6'd21, sb);
        send(32'h0002_2000, 1'b0, 6'd22, sc);
        cancel_r[sb] = 1'b1;
        wait_quiet();

        cur_req = "R6"; eng_lat = 6;
        send(32'h0003_0000, 1'b0, 6'd30, sa);
        send(32'h0003_1000, 1'b0, 6'd31, sb);
        send(32'h0003_2000, 1'b1, 6'd32, sc);
        send(32'h0003_3000, 1'b0, 6'd33, sd);
        cancel_r[sb] = 1'b1; cancel_r[sc] = 1'b1; cancel_r[sd] = 1'b1;
        wait_quiet();

        cur_req = "R7"; eng_lat = 8;
        send(32'h0004_0000, 1'b1, 6'd40, sa);
        send(32'h0004_1000, 1'b0, 6'd41, sb);
        repeat (2) @(negedge clk);
        cancel_r[sa] = 1'b1;
        wait_quiet();

        cur_req = "R10"; eng_lat = 4;
        send(32'h0005_0000, 1'b0, 6'd50, sa);
        send(32'h0005_1000, 1'b1, 6'd51, sb);
        repeat (eng_lat - 1) @(negedge clk);
        cancel_r[sa] = 1'b1;
        wait_quiet();

        cur_req = "R9"; eng_lat = 6;
        send(32'h0006_0000, 1'b0, 6'd60, sa);
        cancel_r[(nslot + 2) % DEPTH] = 1'b1;
        send(32'h0006_1000, 1'b1, 6'd61, sb);
        wait_quiet();

        finish_run();
    end

endmodule